// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Resolver

This block decides which pending interrupt the processor should take next. Eleven sources are placed in six groups. Each group gets one of four priority levels from two byte-wide priority registers on a small special-function-register bus. Every cycle the block looks at the sources that are pending and enabled. It picks the one with the highest level and breaks ties with a fixed polling order. It issues that source as a one-cycle vector request only when the source can preempt the interrupts already being serviced.

Nesting is tracked with a four-bit in-service mask that has one bit per level. Accepting a request sets the bit for its level. A return-from-interrupt pulse clears the highest set bit. The core sees the highest in-service level, together with a flag that tells it whether anything is in service at all. Clearing of request flags, vector address generation and the logic of the individual peripherals belong to the surrounding system.

Top module: `irq_pri_resolver`

## Requirements
- R1: Source indices map to groups as follows: 0..2 to group 0, 3..5 to group 1, 6..7 to group 2, and 8, 9, 10 to groups 3, 4, 5. Index 0 is external line 0, 1 is timer 0, 2 is serial 1, 3 is external line 2, 4 is timer 1, 5 is serial 0, 6 is external line 1, 7 is external line 3, and 8..10 are external lines 4..6.
- R2: The level of group g is {hi_reg[g], lo_reg[g]}. 00 is level 0, the lowest, and 11 is level 3, the highest.
- R3: lo_reg sits at address 0xA9 and hi_reg at 0xB9. Both are readable and writable, and bit g of each register belongs to group g. Bits 7:6 read as zero and ignore writes. The read data is combinational from the address, and any other address reads zero.
- R4: A source takes part in arbitration only when its flag, its enable and the global enable are all 1. A source that is not taking part never blocks one that is.
- R5: Among the participating sources, the one with the highest group level is selected.
- R6: When several participating sources share the top level, the lowest source index wins. This index order is the polling order: ascending group, and within a group external, then timer, then serial.
- R7: A selected source is issued only if nothing is in service, or if its level is strictly above the highest in-service level. A source at the same or a lower level waits for return-from-interrupt pulses.
- R8: The selection is registered. vec_req rises in the cycle after the inputs that cause it and lasts one clock, with vec_idx holding the source index. The same source is not issued again while its level is in service.
- R9: An issue sets the mask bit for its level. A reti pulse clears the highest set bit. svc_any and svc_lvl report whether any bit is set and which is the highest.
- R10: A priority register write affects arbitration from the cycle after the write, and it does not change the in-service mask.
- R11: After reset both priority registers are zero, the mask is empty and vec_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_flag | input | 11 | Pending request flag per source |
| irq_en | input | 11 | Enable per source |
| glb_en | input | 1 | Global interrupt enable |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_req | output | 1 | One-cycle vector request |
| vec_idx | output | 4 | Index of the issued source |
| svc_any | output | 1 | Some level is in service |
| svc_lvl | output | 2 | Highest level in service |

## Verification
The bench builds the block with its default parameters: an 8-bit register bus, the two priority registers at 0xA9 and 0xB9, six groups and four levels. With these values every group can be given every level, and three-deep nesting can be reached (level 0 or 1 below 2, below 3). Same-level ties within a group and across groups are covered, as are writes that lift a blocked source above the level in service.

// File: rtl/irq_pri_pkg.sv
package irq_pri_pkg;

    parameter int NUM_SRC = 11;
    parameter int NUM_GRP = 6;
    parameter int NUM_LVL = 4;
    parameter int LVL_W   = $clog2(NUM_LVL);
    parameter int IDX_W   = 4;

    // Group membership follows source index order (polling order)
    function automatic int grp_of(int s);
        if (s < 3)      return 0;
        else if (s < 6) return 1;
        else if (s < 8) return 2;
        else            return s - 5;
    endfunction

endpackage

// File: rtl/irq_pri_regs.sv
module irq_pri_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int N_GRP  = irq_pri_pkg::NUM_GRP,
    parameter logic [ADDR_W-1:0] ADDR_LO = 8'hA9,
    parameter logic [ADDR_W-1:0] ADDR_HI = 8'hB9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_GRP-1:0]  lo_bits,
    output logic [N_GRP-1:0]  hi_bits
);
    localparam logic [DATA_W-1:0] WMASK = DATA_W'((1 << N_GRP) - 1);

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } pri_t;

    pri_t pri_d, pri_q;

    always_comb begin
        pri_d = pri_q;
        if (we && addr == ADDR_LO) pri_d.lo = wdata & WMASK;
        if (we && addr == ADDR_HI) pri_d.hi = wdata & WMASK;
        rdata = '0;
        if (addr == ADDR_LO) rdata = pri_q.lo;
        if (addr == ADDR_HI) rdata = pri_q.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pri_q <= '0;
        else        pri_q <= pri_d;
    end

    assign lo_bits = pri_q.lo[N_GRP-1:0];
    assign hi_bits = pri_q.hi[N_GRP-1:0];

    // R3
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_LO) |=> lo_bits == $past(wdata[N_GRP-1:0]));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(lo_bits) && $stable(hi_bits)));

endmodule

// File: rtl/irq_pri_pick.sv
module irq_pri_pick #(
    parameter int N_SRC = irq_pri_pkg::NUM_SRC,
    parameter int N_GRP = irq_pri_pkg::NUM_GRP,
    parameter int LVL_W = irq_pri_pkg::LVL_W,
    parameter int IDX_W = irq_pri_pkg::IDX_W
) (
    input  logic [N_SRC-1:0] active,
    input  logic [N_GRP-1:0] lo_bits,
    input  logic [N_GRP-1:0] hi_bits,
    output logic             sel_vld,
    output logic [IDX_W-1:0] sel_idx,
    output logic [LVL_W-1:0] sel_lvl
);
    logic [LVL_W-1:0] src_lvl [N_SRC];

    for (genvar s = 0; s < N_SRC; s++) begin : g_lvl
        localparam int G = irq_pri_pkg::grp_of(s);
        assign src_lvl[s] = {hi_bits[G], lo_bits[G]};
    end

    // Scan from the highest index down; ">=" lets lower indices win ties
    always_comb begin
        sel_vld = 1'b0;
        sel_idx = '0;
        sel_lvl = '0;
        for (int s = N_SRC - 1; s >= 0; s--) begin
            if (active[s] && (!sel_vld || src_lvl[s] >= sel_lvl)) begin
                sel_vld = 1'b1;
                sel_idx = IDX_W'(s);
                sel_lvl = src_lvl[s];
            end
        end
    end

endmodule

// File: rtl/irq_pri_nest.sv
module irq_pri_nest #(
    parameter int N_LVL = irq_pri_pkg::NUM_LVL,
    parameter int LVL_W = irq_pri_pkg::LVL_W,
    parameter int IDX_W = irq_pri_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_vld,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic [LVL_W-1:0] sel_lvl,
    input  logic             reti,
    output logic             vec_req,
    output logic [IDX_W-1:0] vec_idx,
    output logic             svc_any,
    output logic [LVL_W-1:0] svc_lvl
);
    typedef struct packed {
        logic [N_LVL-1:0] mask;
        logic             req;
        logic [IDX_W-1:0] idx;
    } nest_t;

    nest_t st_d, st_q;
    logic  top_any;
    logic [LVL_W-1:0] top_lvl;
    logic  accept;

    always_comb begin
        top_any = 1'b0;
        top_lvl = '0;
        for (int l = 0; l < N_LVL; l++) begin
            if (st_q.mask[l]) begin
                top_any = 1'b1;
                top_lvl = LVL_W'(l);
            end
        end
        accept = sel_vld && (!top_any || sel_lvl > top_lvl);

        st_d = st_q;
        if (reti && top_any) st_d.mask[top_lvl] = 1'b0;
        if (accept)          st_d.mask[sel_lvl] = 1'b1;
        st_d.req = accept;
        st_d.idx = accept ? sel_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_req = st_q.req;
    assign vec_idx = st_q.idx;
    assign svc_any = top_any;
    assign svc_lvl = top_lvl;

    // R8
    req_in_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> svc_any);

    // R9
    accept_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> svc_lvl == $past(sel_lvl));

    // R7
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld && top_any && sel_lvl <= top_lvl) |=> !vec_req);

    // R9
    reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && top_any && !accept) |=>
            $countones(st_q.mask) == $past($countones(st_q.mask)) - 1);

endmodule

// File: rtl/irq_pri_resolver.sv
module irq_pri_resolver #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int N_SRC  = irq_pri_pkg::NUM_SRC,
    parameter int N_GRP  = irq_pri_pkg::NUM_GRP,
    parameter int N_LVL  = irq_pri_pkg::NUM_LVL,
    parameter int IDX_W  = irq_pri_pkg::IDX_W,
    parameter logic [ADDR_W-1:0] ADDR_LO = 8'hA9,
    parameter logic [ADDR_W-1:0] ADDR_HI = 8'hB9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_flag,
    input  logic [N_SRC-1:0]  irq_en,
    input  logic              glb_en,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_we,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              reti,
    output logic              vec_req,
    output logic [IDX_W-1:0]  vec_idx,
    output logic              svc_any,
    output logic [$clog2(N_LVL)-1:0] svc_lvl
);
    localparam int LVL_W = $clog2(N_LVL);

    logic [N_GRP-1:0] lo_bits, hi_bits;
    logic [N_SRC-1:0] active;
    logic             sel_vld;
    logic [IDX_W-1:0] sel_idx;
    logic [LVL_W-1:0] sel_lvl;

    assign active = irq_flag & irq_en & {N_SRC{glb_en}};

    irq_pri_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_GRP(N_GRP),
                   .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .we(sfr_we),
        .wdata(sfr_wdata), .rdata(sfr_rdata),
        .lo_bits(lo_bits), .hi_bits(hi_bits));

    irq_pri_pick #(.N_SRC(N_SRC), .N_GRP(N_GRP), .LVL_W(LVL_W),
                   .IDX_W(IDX_W)) u_pick (
        .active(active), .lo_bits(lo_bits), .hi_bits(hi_bits),
        .sel_vld(sel_vld), .sel_idx(sel_idx), .sel_lvl(sel_lvl));

    irq_pri_nest #(.N_LVL(N_LVL), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_nest (
        .clk(clk), .rst_n(rst_n), .sel_vld(sel_vld), .sel_idx(sel_idx),
        .sel_lvl(sel_lvl), .reti(reti), .vec_req(vec_req),
        .vec_idx(vec_idx), .svc_any(svc_any), .svc_lvl(svc_lvl));

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> vec_idx < IDX_W'(N_SRC));

    // R4
    glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !vec_req);

endmodule

// File: tb/irq_pri_resolver_tb_top.sv
module irq_pri_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] irq_flag = '0;
    logic [10:0] irq_en = '0;
    logic        glb_en = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;
    logic        reti = 1'b0;
    logic        vec_req;
    logic [3:0]  vec_idx;
    logic        svc_any;
    logic [1:0]  svc_lvl;

    int n_run = 0;
    int n_fail = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    irq_pri_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .irq_en(irq_en),
        .glb_en(glb_en), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .reti(reti),
        .vec_req(vec_req), .vec_idx(vec_idx), .svc_any(svc_any),
        .svc_lvl(svc_lvl));

    task automatic check(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: every issued vector is compared with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && vec_req) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8 unexpected vector", int'(vec_idx), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(vec_idx) == e, "R5/R6 vector index", int'(vec_idx), e);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic sfr_write(logic [7:0] a, logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        cyc(1);
        sfr_we = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, int exp, string tag);
        sfr_addr = a;
        #1;
        check(int'(sfr_rdata) == exp, tag, int'(sfr_rdata), exp);
    endtask

    task automatic drain(string tag);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic svc_chk(bit any, int lvl, string tag);
        check(svc_any == any, tag, int'(svc_any), int'(any));
        if (any) check(int'(svc_lvl) == lvl, tag, int'(svc_lvl), lvl);
    endtask

    task automatic reti_pulse();
        reti = 1'b1;
        cyc(1);
        reti = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        // R11 reset state
        check(vec_req == 1'b0, "R11 vec_req", int'(vec_req), 0);
        svc_chk(1'b0, 0, "R11 mask empty");
        rd_chk(8'hA9, 0, "R11 lo_reg");
        rd_chk(8'hB9, 0, "R11 hi_reg");

        // R3 register access
        sfr_write(8'hA9, 8'hFF);
        rd_chk(8'hA9, 8'h3F, "R3 lo_reg upper bits");
        sfr_write(8'hB9, 8'hC5);
        rd_chk(8'hB9, 8'h05, "R3 hi_reg");
        rd_chk(8'h80, 0, "R3 other address");
        sfr_write(8'hA9, 8'h00);
        sfr_write(8'hB9, 8'h00);

        irq_en = '1;
        glb_en = 1'b1;

        // R6 same-level tie, all level 0
        irq_flag[2] = 1'b1; irq_flag[5] = 1'b1; irq_flag[9] = 1'b1;
        exp_q.push_back(2);
        cyc(1);
        check(vec_req == 1'b1, "R8 issue cycle", int'(vec_req), 1);
        irq_flag[2] = 1'b0;
        cyc(1);
        check(vec_req == 1'b0, "R8 single pulse", int'(vec_req), 0);
        cyc(2);
        drain("R6 tie order");
        svc_chk(1'b1, 0, "R9 level 0 in service");
        exp_q.push_back(5);
        reti_pulse();
        cyc(1);
        irq_flag[5] = 1'b0;
        cyc(2);
        drain("R7 wait for reti");
        exp_q.push_back(9);
        reti_pulse();
        cyc(1);
        irq_flag[9] = 1'b0;
        cyc(2);
        drain("R6 next in order");
        reti_pulse();
        cyc(1);
        svc_chk(1'b0, 0, "R9 all returned");

        // R4 enables: disabled level-3 source must not block a level-0 one
        sfr_write(8'hA9, 8'h01);
        sfr_write(8'hB9, 8'h01);
        irq_en = 11'h7FE;
        irq_flag[0] = 1'b1; irq_flag[3] = 1'b1;
        exp_q.push_back(3);
        cyc(1);
        irq_flag[3] = 1'b0;
        cyc(4);
        drain("R4 disabled source ignored");
        svc_chk(1'b1, 0, "R4 level 0 taken");
        reti_pulse();
        cyc(1);
        glb_en = 1'b0;
        irq_en = '1;
        cyc(3);
        check(vec_req == 1'b0, "R4 global off", int'(vec_req), 0);
        glb_en = 1'b1;
        exp_q.push_back(0);
        cyc(1);
        check(vec_req == 1'b1, "R4 global on", int'(vec_req), 1);
        irq_flag[0] = 1'b0;
        cyc(2);
        drain("R4 source 0");
        svc_chk(1'b1, 3, "R2 group 0 at level 3");
        reti_pulse();
        cyc(1);

        // R5/R7/R1/R2: g0=1, g3=2, g4=2, g5=3
        sfr_write(8'hA9, 8'h21);
        sfr_write(8'hB9, 8'h38);
        irq_flag[0] = 1'b1; irq_flag[9] = 1'b1;
        exp_q.push_back(9);
        cyc(1);
        irq_flag[9] = 1'b0;
        cyc(2);
        drain("R5 higher level wins");
        svc_chk(1'b1, 2, "R1 source 9 in group 4 at level 2");
        irq_flag[10] = 1'b1;
        exp_q.push_back(10);
        cyc(1);
        irq_flag[10] = 1'b0;
        cyc(2);
        drain("R7 preempt");
        svc_chk(1'b1, 3, "R9 nested level 3");
        irq_flag[8] = 1'b1;
        cyc(3);
        reti_pulse();
        cyc(3);
        svc_chk(1'b1, 2, "R9 pop to level 2");
        drain("R7 same level waits");
        exp_q.push_back(8);
        reti_pulse();
        cyc(1);
        irq_flag[8] = 1'b0;
        cyc(2);
        drain("R1 source 8 after return");
        svc_chk(1'b1, 2, "R1 group 3 at level 2");
        exp_q.push_back(0);
        reti_pulse();
        cyc(1);
        irq_flag[0] = 1'b0;
        cyc(2);
        drain("R5 lower level last");
        svc_chk(1'b1, 1, "R2 level 1");
        reti_pulse();
        cyc(1);
        svc_chk(1'b0, 0, "R9 empty");

        // R10 priority write while a level is in service
        sfr_write(8'hA9, 8'h00);
        sfr_write(8'hB9, 8'h00);
        irq_flag[0] = 1'b1;
        exp_q.push_back(0);
        cyc(1);
        irq_flag[0] = 1'b0;
        cyc(2);
        drain("R10 setup");
        irq_flag[4] = 1'b1;
        cyc(3);
        sfr_write(8'hB9, 8'h02);
        check(vec_req == 1'b0, "R10 not in write cycle", int'(vec_req), 0);
        svc_chk(1'b1, 0, "R10 mask untouched");
        exp_q.push_back(4);
        cyc(1);
        check(vec_req == 1'b1, "R10 cycle after write", int'(vec_req), 1);
        irq_flag[4] = 1'b0;
        cyc(2);
        drain("R10 raised source issued");
        svc_chk(1'b1, 2, "R9 level 2 over 0");
        reti_pulse();
        cyc(1);
        svc_chk(1'b1, 0, "R9 back to level 0");
        reti_pulse();
        cyc(1);
        svc_chk(1'b0, 0, "R9 final empty");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule